// File: doc/BRIEF.md
# Packet Interrupt Delay Timer

This block raises a delayed completion interrupt for a streaming DMA channel. Packet interrupts can then be coalesced while the wait for software stays bounded. When a packet finishes, the timer arms. It then counts coarse intervals, each a fixed number of scatter-gather clock cycles (125 by default). When the programmed number of intervals has passed, it sets a sticky interrupt flag.

If another packet starts while the timer is counting, the count is cancelled, because that packet's own completion will re-arm the timer. A delay setting of zero switches the timer off completely. Software clears the flag with an acknowledge pulse. A status output shows whether the timer is currently counting.

Top module: `pkt_irq_delay_timer`

## Requirements
- R1: After a synchronous active-low reset, `delay_irq` and `timer_busy` are both 0.
- R2: When `delay_cfg` is 0, an end-of-packet pulse does not arm the timer and no interrupt is raised. Setting `delay_cfg` to 0 while the timer counts makes `timer_busy` 0 on the next cycle.
- R3: With `delay_cfg` = N (1 to 255), `delay_irq` rises exactly N × 125 clock cycles after the clock edge that samples `eop_pulse`.
- R4: `eop_pulse` with a non-zero setting makes `timer_busy` 1 on the next cycle. A further `eop_pulse` while the timer counts restarts the full delay from that pulse.
- R5: `sop_pulse` without `eop_pulse` while the timer counts makes `timer_busy` 0 on the next cycle, and that count raises no interrupt.
- R6: On expiry, `delay_irq` becomes 1 and `timer_busy` becomes 0 at the same edge. No further interrupt is raised until the next `eop_pulse`.
- R7: `delay_irq` stays 1 until `irq_ack` is sampled high. It is then 0 on the next cycle, unless a new expiry occurs in that same cycle.
- R8: An `irq_ack` sampled in the same cycle as an expiry leaves `delay_irq` at 1.
- R9: When `eop_pulse` and `sop_pulse` are sampled together, the end-of-packet pulse wins and the timer re-arms from zero.
- R10: Lowering `delay_cfg` to a value at or below the number of intervals already counted causes an expiry at the next interval boundary. Expiry only ever happens at an interval boundary.
- R11: The largest setting, 255, gives an interrupt exactly 31875 cycles after the end-of-packet pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scatter-gather clock |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_cfg | input | 8 | Delay in intervals; 0 disables the timer |
| eop_pulse | input | 1 | One-cycle end-of-packet strobe; arms the timer |
| sop_pulse | input | 1 | One-cycle new-packet strobe; cancels counting |
| irq_ack | input | 1 | Clears the interrupt flag |
| delay_irq | output | 1 | Sticky delayed interrupt flag |
| timer_busy | output | 1 | 1 while the timer counts intervals |

## Verification
The timer is driven with several patterns, and a scoreboard predicts the exact cycle of every interrupt rise:
- **Plain arm-and-expire** at settings 2, 1 and 255 confirms the N × 125 latency.
- **A second end-of-packet mid-count** separates a restart from a continuing count, because only the later deadline may fire.
- **A new-packet pulse mid-count** and **a zero setting** must both produce no rise, so the scoreboard reports any unexpected interrupt.
- **End-of-packet and new-packet together** separates the two possible priorities.
- **Lowering the setting mid-count** separates comparing against the live setting from comparing against a latched one.
- **An acknowledge placed exactly on the expiry edge** separates set-wins from clear-wins in the flag.

// File: rtl/pidt_pkg.sv
// Package: shared defaults and state type for the packet interrupt delay timer.
// Assumes nothing beyond a single clock domain.
package pidt_pkg;
    localparam int unsigned TICK_DIV_DEF = 125;  // clock cycles per interval
    localparam int unsigned CFG_W_DEF    = 8;    // width of the delay setting

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/pidt_prescaler.sv
// Interval prescaler: divides the clock by DIV and emits a one-cycle tick at
// the last cycle of each interval while enabled.
// Assumes DIV >= 2. A clear restarts the interval so the next one is full length.
module pidt_prescaler #(
    parameter int unsigned DIV = pidt_pkg::TICK_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int unsigned W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Cycle counter within the current interval
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick on the final cycle of an interval
    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/pidt_interval_ctr.sv
// Interval counter: arms on end-of-packet and counts prescaler ticks. It
// flags expiry on the tick where the count reaches the live setting.
// Assumes eop/sop are one-cycle strobes. The setting may change at any time
// and is compared as it stands on each tick. Priority: eop > sop > off > expiry.
module pidt_interval_ctr #(
    parameter int unsigned CFG_W = pidt_pkg::CFG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             eop,
    input  logic             sop,
    input  logic             tick,
    output logic             busy,
    output logic             restart,
    output logic             expire
);
    import pidt_pkg::*;

    tmr_state_e       state_q;
    logic [CFG_W-1:0] count_q;
    logic [CFG_W:0]   next_cnt;
    logic             cfg_off;
    logic             running;

    // Decode the disabled setting and the count after this tick
    always_comb begin
        cfg_off  = (cfg == '0);
        running  = (state_q == TMR_RUN);
        next_cnt = {1'b0, count_q} + 1'b1;
    end

    // Expiry when the tick brings the count to or past the setting
    always_comb begin
        expire = running && tick && !eop && !sop && !cfg_off
                 && (next_cnt >= {1'b0, cfg});
    end

    // Any event that starts the interval over
    assign restart = eop || sop || cfg_off || expire;
    assign busy    = running;

    // Armed state and count of elapsed intervals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            count_q <= '0;
        end else if (eop) begin
            state_q <= cfg_off ? TMR_IDLE : TMR_RUN;
            count_q <= '0;
        end else if (sop || cfg_off || expire) begin
            state_q <= TMR_IDLE;
            count_q <= '0;
        end else if (running && tick) begin
            count_q <= next_cnt[CFG_W-1:0];
        end
    end
endmodule

// File: rtl/pidt_irq_flag.sv
// Sticky interrupt flag: set by expiry, cleared by acknowledge.
// Assumes set takes priority over a simultaneous acknowledge.
module pidt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic flag
);
    // Hold the flag until acknowledged; a new expiry wins over ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pkt_irq_delay_timer.sv
// Packet interrupt delay timer top. It arms on end-of-packet, is cancelled
// by a new packet, and raises a sticky interrupt after delay_cfg intervals
// of TICK_DIV cycles. A setting of zero disables it.
// Assumes a single clock domain and a synchronous active-low reset.
module pkt_irq_delay_timer #(
    parameter int unsigned TICK_DIV = pidt_pkg::TICK_DIV_DEF,
    parameter int unsigned CFG_W    = pidt_pkg::CFG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] delay_cfg,
    input  logic             eop_pulse,
    input  logic             sop_pulse,
    input  logic             irq_ack,
    output logic             delay_irq,
    output logic             timer_busy
);
    logic interval_tick;
    logic restart;
    logic expire;

    // Interval tick generator
    pidt_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_busy),
        .clear (restart),
        .tick  (interval_tick)
    );

    // Arm/cancel control and interval count
    pidt_interval_ctr #(.CFG_W(CFG_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (delay_cfg),
        .eop     (eop_pulse),
        .sop     (sop_pulse),
        .tick    (interval_tick),
        .busy    (timer_busy),
        .restart (restart),
        .expire  (expire)
    );

    // Sticky interrupt output
    pidt_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .ack   (irq_ack),
        .flag  (delay_irq)
    );
endmodule

// File: rtl/pidt_checker.sv
// Assertion checker for the packet interrupt delay timer, bound to the top.
// Assumes the same clock and synchronous active-low reset as the design.
module pidt_checker #(
    parameter int unsigned CFG_W = pidt_pkg::CFG_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] delay_cfg,
    input logic             eop_pulse,
    input logic             sop_pulse,
    input logic             irq_ack,
    input logic             delay_irq,
    input logic             timer_busy,
    input logic             interval_tick,
    input logic             expire
);
    assert_zero_cfg_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_cfg == '0 && !delay_irq) |=> !delay_irq);

    assert_zero_cfg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_cfg == '0) |=> !timer_busy);

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        interval_tick |=> !interval_tick);

    assert_eop_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_pulse && delay_cfg != '0) |=> timer_busy);

    assert_sop_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_pulse && !eop_pulse) |=> !timer_busy);

    assert_expiry_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (delay_irq && !timer_busy));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_irq && !irq_ack) |=> delay_irq);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_irq && irq_ack && !expire) |=> !delay_irq);

    assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_ack) |=> delay_irq);

    assert_expire_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (interval_tick && timer_busy));
endmodule

bind pkt_irq_delay_timer pidt_checker #(.CFG_W(CFG_W)) u_pidt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .delay_cfg     (delay_cfg),
    .eop_pulse     (eop_pulse),
    .sop_pulse     (sop_pulse),
    .irq_ack       (irq_ack),
    .delay_irq     (delay_irq),
    .timer_busy    (timer_busy),
    .interval_tick (interval_tick),
    .expire        (expire)
);

// File: tb/pkt_irq_delay_timer_tb_top.sv
module pkt_irq_delay_timer_tb_top;
    localparam int DIV = 125;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] delay_cfg = 8'd0;
    logic       eop_pulse = 1'b0;
    logic       sop_pulse = 1'b0;
    logic       irq_ack = 1'b0;
    logic       delay_irq;
    logic       timer_busy;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    int  exp_q[$];
    logic irq_prev = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pkt_irq_delay_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_cfg  (delay_cfg),
        .eop_pulse  (eop_pulse),
        .sop_pulse  (sop_pulse),
        .irq_ack    (irq_ack),
        .delay_irq  (delay_irq),
        .timer_busy (timer_busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: every rising interrupt is matched against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (delay_irq && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected interrupt", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R3 interrupt cycle", cyc, e);
                end
            end
        end
        irq_prev <= delay_irq;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected < %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: end-of-packet pulse; returns the edge that samples it
    task automatic do_eop(output int edge_n);
        eop_pulse = 1'b1;
        edge_n = cyc + 1;
        @(negedge clk);
        eop_pulse = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        int e;
        int e2;
        repeat (3) @(negedge clk);
        check(delay_irq == 1'b0, "R1 irq after reset", delay_irq, 0);
        check(timer_busy == 1'b0, "R1 busy after reset", timer_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: plain delay of 2 intervals
        delay_cfg = 8'd2;
        do_eop(e);
        exp_q.push_back(e + 2 * DIV);
        check(timer_busy == 1'b1, "R4 busy after eop", timer_busy, 1);
        wait_to(e + 2 * DIV);
        check(delay_irq == 1'b1, "R3 irq at 2 intervals", delay_irq, 1);
        check(timer_busy == 1'b0, "R6 idle after expiry", timer_busy, 0);
        repeat (20) @(negedge clk);
        check(delay_irq == 1'b1, "R7 irq sticky", delay_irq, 1);
        repeat (400) @(negedge clk);
        check(timer_busy == 1'b0, "R6 no re-arm without eop", timer_busy, 0);
        do_ack();
        check(delay_irq == 1'b0, "R7 ack clears", delay_irq, 0);

        // R2: zero setting disables
        delay_cfg = 8'd0;
        do_eop(e);
        check(timer_busy == 1'b0, "R2 no arm at zero", timer_busy, 0);
        repeat (300) @(negedge clk);
        check(delay_irq == 1'b0, "R2 no irq at zero", delay_irq, 0);

        // R2: setting forced to zero while counting
        delay_cfg = 8'd5;
        do_eop(e);
        repeat (10) @(negedge clk);
        delay_cfg = 8'd0;
        @(negedge clk);
        check(timer_busy == 1'b0, "R2 disarm on zero", timer_busy, 0);
        repeat (700) @(negedge clk);

        // R5: new packet cancels
        delay_cfg = 8'd3;
        do_eop(e);
        repeat (200) @(negedge clk);
        sop_pulse = 1'b1;
        @(negedge clk);
        sop_pulse = 1'b0;
        check(timer_busy == 1'b0, "R5 sop cancels", timer_busy, 0);
        repeat (500) @(negedge clk);
        check(delay_irq == 1'b0, "R5 no irq after cancel", delay_irq, 0);

        // R4: second eop restarts the delay
        delay_cfg = 8'd2;
        do_eop(e);
        repeat (100) @(negedge clk);
        do_eop(e2);
        exp_q.push_back(e2 + 2 * DIV);
        wait_to(e + 2 * DIV);
        check(delay_irq == 1'b0, "R4 old deadline ignored", delay_irq, 0);
        wait_to(e2 + 2 * DIV);
        check(delay_irq == 1'b1, "R4 restarted deadline", delay_irq, 1);
        do_ack();

        // R9: eop and sop together, eop wins
        delay_cfg = 8'd1;
        do_eop(e);
        repeat (50) @(negedge clk);
        eop_pulse = 1'b1;
        sop_pulse = 1'b1;
        e2 = cyc + 1;
        @(negedge clk);
        eop_pulse = 1'b0;
        sop_pulse = 1'b0;
        exp_q.push_back(e2 + DIV);
        check(timer_busy == 1'b1, "R9 eop wins over sop", timer_busy, 1);
        wait_to(e2 + DIV);
        check(delay_irq == 1'b1, "R9 irq after re-arm", delay_irq, 1);
        do_ack();

        // R10: lower the setting below the elapsed count
        delay_cfg = 8'd10;
        do_eop(e);
        wait_to(e + 3 * DIV + 10);
        delay_cfg = 8'd2;
        exp_q.push_back(e + 4 * DIV);
        wait_to(e + 4 * DIV);
        check(delay_irq == 1'b1, "R10 expiry on next tick", delay_irq, 1);
        do_ack();

        // R8: acknowledge on the expiry edge
        delay_cfg = 8'd1;
        do_eop(e);
        exp_q.push_back(e + DIV);
        wait_to(e + DIV - 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(delay_irq == 1'b1, "R8 set beats ack", delay_irq, 1);
        do_ack();

        // R11: largest setting
        delay_cfg = 8'd255;
        do_eop(e);
        exp_q.push_back(e + 255 * DIV);
        wait_to(e + 255 * DIV - 1);
        check(delay_irq == 1'b0, "R11 not early", delay_irq, 0);
        @(negedge clk);
        check(delay_irq == 1'b1, "R11 irq at 31875", delay_irq, 1);
        do_ack();

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3 all interrupts seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule